// File: doc/BRIEF.md
# Programmable Sample Acquisition Timer

This block times the tracking phase of a sample-and-hold front end inside a sequenced analog-to-digital converter. When a start strobe arrives, the block captures two values from the active instruction. The first is a 4-bit delay code. The second is a mode flag that selects either a full-resolution conversion or a short-resolution conversion or limit comparison. The block then drives a track output high for a window whose length depends on both values. One cycle after the window closes, it pulses a done strobe so that the sequencer can start the hold and convert phase.

The window length is a fixed base that depends on the mode, plus two clock cycles for each unit of the delay code. The full-resolution base is 9 cycles and the short or compare base is 2 cycles. Both bases and the code width are parameters. The captured values define the whole window. A start strobe that arrives while the window is open is ignored, and so is any change on the code or mode inputs during the window.

Top module: `acq_window_timer`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) drives `track_o` and `done_o` low from the next cycle and abandons any open window without a done pulse.
- R2: The first cycle after the edge that samples `start_i` high while `track_o` is low is the first cycle in which `track_o` is high.
- R3: With `short_mode_i` = 0 (full resolution), `track_o` stays high for exactly 9 + 2·code cycles, where code is the 4-bit `code_i` as an unsigned value.
- R4: With `short_mode_i` = 1 (short resolution or limit compare), `track_o` stays high for exactly 2 + 2·code cycles.
- R5: Every code from 0 to 15 is accepted, and each unit of code adds exactly two cycles to the window in either mode.
- R6: `done_o` is high for exactly one cycle, which is the first cycle in which `track_o` is low after a window. It is never high at any other time.
- R7: A `start_i` pulse while `track_o` is high is ignored: the window neither restarts nor changes length.
- R8: `code_i` and `short_mode_i` are captured at the accepted start. Changes on them while `track_o` is high do not alter the window length.
- R9: A start sampled in the cycle where `done_o` is high is accepted, so windows can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe for one acquisition window |
| code_i | input | 4 | Delay code; each unit lengthens the window by two cycles |
| short_mode_i | input | 1 | 0 selects the full-resolution base, 1 selects the short or compare base |
| track_o | output | 1 | High while the sample-and-hold should track |
| done_o | output | 1 | One-cycle strobe in the first cycle after the window |

## Verification
The hardest situations to reach from the ports involve inputs that change in the middle of an open window. One is a second start strobe that arrives while the window is open. The other is a new code and mode presented before the window ends. The bench therefore counts the track cycles of each window. At a chosen cycle inside the window, it drives a start with inverted code and mode, or it changes only the code and mode. It then compares the measured length with the length computed from the values given at the accepted start. A start placed in the done cycle and a reset pulsed in the middle of a window cover the remaining edges of the control sequence.

// File: rtl/acqw_pkg.sv
package acqw_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_TRACK = 2'd1,
        SEQ_DONE  = 2'd2
    } seq_state_e;

    // Width needed to hold the longest window for the given configuration.
    function automatic int win_len_width(input int code_w, input int full_base, input int short_base);
        int max_base;
        int max_len;
        max_base = (full_base > short_base) ? full_base : short_base;
        max_len  = max_base + 2 * ((1 << code_w) - 1);
        return $clog2(max_len + 1);
    endfunction

endpackage

// File: rtl/acqw_len_calc.sv
module acqw_len_calc #(
    parameter int CODE_W     = 4,
    parameter int FULL_BASE  = 9,
    parameter int SHORT_BASE = 2,
    parameter int LEN_W      = 6
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              short_mode_i,
    output logic [LEN_W-1:0]  len_o
);

    localparam logic [LEN_W-1:0] FULL_BASE_V  = LEN_W'(FULL_BASE);
    localparam logic [LEN_W-1:0] SHORT_BASE_V = LEN_W'(SHORT_BASE);

    logic [LEN_W-1:0] base;
    logic [LEN_W-1:0] extra;

    always_comb begin
        base  = short_mode_i ? SHORT_BASE_V : FULL_BASE_V;
        extra = LEN_W'(code_i) << 1;
        len_o = base + extra;
    end

endmodule

// File: rtl/acqw_countdown.sv
module acqw_countdown #(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             run_i,
    output logic             last_o
);

    typedef struct packed {
        logic [LEN_W-1:0] remain;
    } cnt_regs_t;

    cnt_regs_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d.remain = len_i;
        end else if (run_i && (cnt_q.remain != '0)) begin
            cnt_d.remain = cnt_q.remain - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q.remain == LEN_W'(1));

endmodule

// File: rtl/acqw_seq.sv
module acqw_seq
    import acqw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic last_i,
    output logic load_o,
    output logic track_o,
    output logic done_o
);

    typedef struct packed {
        seq_state_e state;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d  = seq_q;
        load_o = 1'b0;
        unique case (seq_q.state)
            SEQ_IDLE, SEQ_DONE: begin
                if (start_i) begin
                    load_o      = 1'b1;
                    seq_d.state = SEQ_TRACK;
                end else begin
                    seq_d.state = SEQ_IDLE;
                end
            end
            SEQ_TRACK: begin
                if (last_i) begin
                    seq_d.state = SEQ_DONE;
                end
            end
            default: seq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.state <= SEQ_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign track_o = (seq_q.state == SEQ_TRACK);
    assign done_o  = (seq_q.state == SEQ_DONE);

endmodule

// File: rtl/acq_window_timer.sv
module acq_window_timer #(
    parameter int CODE_W     = 4,
    parameter int FULL_BASE  = 9,
    parameter int SHORT_BASE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              short_mode_i,
    output logic              track_o,
    output logic              done_o
);

    localparam int LEN_W = acqw_pkg::win_len_width(CODE_W, FULL_BASE, SHORT_BASE);

    logic [LEN_W-1:0] win_len;
    logic             load;
    logic             last;

    acqw_len_calc #(
        .CODE_W    (CODE_W),
        .FULL_BASE (FULL_BASE),
        .SHORT_BASE(SHORT_BASE),
        .LEN_W     (LEN_W)
    ) u_len_calc (
        .code_i      (code_i),
        .short_mode_i(short_mode_i),
        .len_o       (win_len)
    );

    acqw_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start_i(start_i),
        .last_i (last),
        .load_o (load),
        .track_o(track_o),
        .done_o (done_o)
    );

    acqw_countdown #(
        .LEN_W(LEN_W)
    ) u_countdown (
        .clk   (clk),
        .rst   (rst),
        .load_i(load),
        .len_i (win_len),
        .run_i (track_o),
        .last_o(last)
    );

endmodule

// File: rtl/acqw_checker.sv
module acqw_checker #(
    parameter int CODE_W     = 4,
    parameter int FULL_BASE  = 9,
    parameter int SHORT_BASE = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [CODE_W-1:0] code_i,
    input logic              short_mode_i,
    input logic              track_o,
    input logic              done_o
);

    logic prev_track_q;
    logic prev_start_q;
    int   exp_len_q;
    int   run_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_track_q <= 1'b0;
            prev_start_q <= 1'b0;
            exp_len_q    <= 0;
            run_cnt_q    <= 0;
        end else begin
            prev_track_q <= track_o;
            prev_start_q <= start_i && !track_o;
            if (start_i && !track_o) begin
                exp_len_q <= (short_mode_i ? SHORT_BASE : FULL_BASE) + 2 * int'(code_i);
            end
            run_cnt_q <= track_o ? run_cnt_q + 1 : 0;
        end
    end

    // R1: reset clears both outputs on the following cycle
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!track_o && !done_o));

    // R2: track only rises after an accepted start
    assert_rise_after_start_R2: assert property (@(posedge clk) disable iff (rst)
        (!prev_track_q && track_o) |-> prev_start_q);

    // R3, R4, R7, R8: window length equals the value captured at the accepted start
    assert_window_length_R3: assert property (@(posedge clk) disable iff (rst)
        (prev_track_q && !track_o) |-> (run_cnt_q == exp_len_q));

    // R6: done follows every window close
    assert_done_on_close_R6: assert property (@(posedge clk) disable iff (rst)
        (prev_track_q && !track_o) |-> done_o);

    // R6: done only right after a window
    assert_done_after_track_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (prev_track_q && !track_o));

    // R6: done lasts a single cycle
    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

bind acq_window_timer acqw_checker #(
    .CODE_W    (CODE_W),
    .FULL_BASE (FULL_BASE),
    .SHORT_BASE(SHORT_BASE)
) u_acqw_checker (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .code_i      (code_i),
    .short_mode_i(short_mode_i),
    .track_o     (track_o),
    .done_o      (done_o)
);

// File: tb/acq_window_timer_bench.sv
`timescale 1ns/1ps
module acq_window_timer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [3:0] code_i = 4'd0;
    logic       short_mode_i = 1'b0;
    logic       track_o;
    logic       done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    acq_window_timer u_acq_window_timer (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .code_i      (code_i),
        .short_mode_i(short_mode_i),
        .track_o     (track_o),
        .done_o      (done_o)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [3:0] code, input logic mode);
        return (mode ? 2 : 9) + 2 * int'(code);
    endfunction

    // Called at a negedge. Drives a start here and checks the rise and the length.
    // dist_kind 1 changes code/mode mid window (R8); 2 also pulses start (R7).
    // Returns at the negedge of the first cycle with track low, after checking done.
    task automatic run_window(input logic [3:0] code, input logic mode, input int dist_at,
                              input int dist_kind, input string rise_req, input string len_req);
        int cnt;
        start_i      = 1'b1;
        code_i       = code;
        short_mode_i = mode;
        @(negedge clk);
        start_i = 1'b0;
        check(track_o === 1'b1, rise_req, "track high in cycle after start", int'(track_o), 1);
        cnt = 0;
        while (track_o === 1'b1 && cnt < 100) begin
            cnt++;
            if (cnt == dist_at && dist_kind != 0) begin
                code_i       = ~code;
                short_mode_i = ~mode;
                if (dist_kind == 2) start_i = 1'b1;
            end
            @(negedge clk);
            start_i = 1'b0;
        end
        check(cnt == exp_len(code, mode), len_req, "track length", cnt, exp_len(code, mode));
        check(done_o === 1'b1, "R6", "done in first cycle after track", int'(done_o), 1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle after reset
        check(track_o === 1'b0, "R1", "track after reset", int'(track_o), 0);
        check(done_o === 1'b0, "R1", "done after reset", int'(done_o), 0);

        // R3, R4, R5: full sweep of codes in both modes
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 16; c++) begin
                run_window(4'(c), 1'(m), 0, 0, "R2", (m == 0) ? "R3" : "R4");
                @(negedge clk);
                check(done_o === 1'b0, "R6", "done lasts one cycle", int'(done_o), 0);
                check(track_o === 1'b0, "R5", "idle after window", int'(track_o), 0);
            end
        end

        // R7: second start inside the window is ignored
        run_window(4'd3, 1'b0, 4, 2, "R2", "R7");
        @(negedge clk);
        check(track_o === 1'b0, "R7", "no restart after ignored start", int'(track_o), 0);
        run_window(4'd0, 1'b1, 1, 2, "R2", "R7");
        @(negedge clk);
        check(track_o === 1'b0, "R7", "no restart on short window", int'(track_o), 0);

        // R8: code and mode changes mid window have no effect
        run_window(4'd15, 1'b1, 3, 1, "R2", "R8");
        @(negedge clk);
        run_window(4'd0, 1'b0, 2, 1, "R2", "R8");
        @(negedge clk);
        check(done_o === 1'b0, "R8", "done clear after window", int'(done_o), 0);

        // R9: start in the done cycle chains windows
        run_window(4'd1, 1'b1, 0, 0, "R2", "R4");
        run_window(4'd2, 1'b0, 0, 0, "R9", "R9");
        run_window(4'd0, 1'b1, 0, 0, "R9", "R9");
        @(negedge clk);
        check(done_o === 1'b0, "R9", "done clear after chain", int'(done_o), 0);

        // R1: reset in the middle of a window abandons it
        start_i = 1'b1; code_i = 4'd5; short_mode_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(track_o === 1'b0, "R1", "track after mid-window reset", int'(track_o), 0);
        for (int k = 0; k < 20; k++) begin
            check(done_o === 1'b0 && track_o === 1'b0, "R1", "no done after abandoned window",
                  int'(done_o) + int'(track_o), 0);
            @(negedge clk);
        end

        // R3 after reset: normal operation resumes
        run_window(4'd7, 1'b0, 0, 0, "R2", "R3");
        @(negedge clk);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule